// File: doc/BRIEF.md
# Cascaded System Clock Divider Controller

This block produces clock-enable strobes for a chip whose logic all runs on one fast core clock. A bus-rate strobe fires once per divided period, where the period is 1, 2, 3 or 4 core cycles. A peripheral-rate strobe fires once every 2, 4 or 8 bus strobes. Logic that should run at the bus rate or the peripheral rate keeps the core clock and advances only in cycles where its strobe is high. A gate request forces the bus strobe low for low-power operation. Because the peripheral divider counts bus strobes, the gate request also freezes the peripheral divider.

A separate slow section runs on its own 32.768 kHz clock with its own reset. It divides that clock by 32768 and produces a one-cycle tick once per second for a real-time counter. It does not depend on the core clock or the core reset.

Each divide select is sampled only at the start of a divided period. A select change mid-period therefore never produces a short or malformed period.

Top module: `sysclk_strobe_gen`

## Requirements
- R1: bus_sel picks the bus period N = bus_sel + 1 core cycles (encodings 0,1,2,3 give 1,2,3,4). While bus_sel is steady and ungated, bus_en is high in exactly the last cycle of every period.
- R2: With bus_sel = 0 and gate_req low, bus_en is high in every core cycle.
- R3: With bus_sel = 2, bus_en is high in one of every three core cycles, at cycles 2, 5, 8, ... after reset.
- R4: per_sel picks the peripheral period M in bus strobes (0 gives 2, 1 gives 4, 2 gives 8). per_en is high only together with bus_en, on every M-th bus strobe.
- R5: per_sel = 3 behaves as divide-by-8.
- R6: While gate_req is high, bus_en and per_en are low. The bus counter keeps running, so the bus strobe phase is unchanged when the gate is released.
- R7: Gated cycles do not advance the peripheral divider. After the gate is released, it resumes from the count it held.
- R8: bus_sel is sampled in the first cycle of each bus period. per_sel is sampled on the bus strobe that opens each peripheral period. A change at any other time takes effect only from the next period.
- R9: While rst_core_n is low, bus_en and per_en are low. After release, cycle 0 starts both counts at zero, the first bus_en falls in cycle N-1, and the first per_en falls on the M-th bus strobe.
- R10: sec_tick is high for one clk_slow cycle in every 32768. The first tick is in slow cycle 32767 after rst_slow_n is released.
- R11: The slow section keeps running while rst_core_n is held low and clk_core is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Fast core clock |
| rst_core_n | input | 1 | Asynchronous active-low reset of the fast section |
| bus_sel | input | 2 | Bus period select (N = value + 1) |
| per_sel | input | 2 | Peripheral period select (0:2, 1:4, 2 and 3:8 bus strobes) |
| gate_req | input | 1 | Forces the bus strobe low |
| clk_slow | input | 1 | 32.768 kHz slow clock |
| rst_slow_n | input | 1 | Asynchronous active-low reset of the slow section |
| bus_en | output | 1 | Bus-rate enable strobe |
| per_en | output | 1 | Peripheral-rate enable strobe |
| sec_tick | output | 1 | Once-per-second tick, one clk_slow cycle wide |

## Verification
bus_en and per_en are decoded from registered counts, combined with the same-cycle select and gate inputs. Both are therefore due in the same core cycle as the inputs that decide them. The bench drives inputs just after a rising edge and samples both strobes 8 ns later, before the next edge. Its period model then advances by exactly one cycle. sec_tick is due in slow cycle 32767 after slow reset release and every 32768 cycles after that. It is sampled mid-cycle on clk_slow while the core clock is stopped and the core reset is held.

// File: rtl/sysclk_div_pkg.sv
package sysclk_div_pkg;

    typedef enum logic [1:0] {
        PER_DIV2 = 2'd0,
        PER_DIV4 = 2'd1,
        PER_DIV8 = 2'd2,
        PER_SPARE = 2'd3
    } per_sel_e;

    // terminal count (period minus one) of the peripheral divider
    function automatic logic [2:0] per_term(input logic [1:0] sel);
        unique case (per_sel_e'(sel))
            PER_DIV2: per_term = 3'd1;
            PER_DIV4: per_term = 3'd3;
            PER_DIV8: per_term = 3'd7;
            PER_SPARE: per_term = 3'd7;   // spare encoding falls back to divide-by-8
        endcase
    endfunction

endpackage

// File: rtl/busrate_div.sv
module busrate_div #(
    parameter int SEL_W = 2,
    localparam int CNT_W = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             gate,
    output logic             strobe
);
    logic [CNT_W-1:0] cnt;
    logic [SEL_W-1:0] held_sel;
    logic [SEL_W-1:0] eff_sel;
    logic             wrap;

    always_comb begin
        // the select is live only in the first cycle of a period
        eff_sel = (cnt == '0) ? sel : held_sel;
        wrap    = (cnt == CNT_W'(eff_sel));
        strobe  = wrap && !gate && rst_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            held_sel <= '0;
        end else begin
            cnt <= wrap ? '0 : cnt + CNT_W'(1);
            if (cnt == '0) begin
                held_sel <= sel;
            end
        end
    end
endmodule

// File: rtl/perrate_div.sv
module perrate_div
    import sysclk_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       adv,
    output logic       strobe
);
    logic [2:0] cnt;
    logic [1:0] held_sel;
    logic [2:0] term;
    logic       at_end;

    always_comb begin
        term   = per_term((cnt == 3'd0) ? sel : held_sel);
        at_end = (cnt == term);
        strobe = adv && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= 3'd0;
            held_sel <= 2'd0;
        end else if (adv) begin
            cnt <= at_end ? 3'd0 : cnt + 3'd1;
            if (cnt == 3'd0) begin
                held_sel <= sel;
            end
        end
    end
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
    parameter int DIV = 32768,
    localparam int CW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [CW-1:0] cnt;

    always_comb tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sysclk_strobe_gen.sv
module sysclk_strobe_gen #(
    parameter int SLOW_DIV = 32768
) (
    input  logic       clk_core,
    input  logic       rst_core_n,
    input  logic [1:0] bus_sel,
    input  logic [1:0] per_sel,
    input  logic       gate_req,
    input  logic       clk_slow,
    input  logic       rst_slow_n,
    output logic       bus_en,
    output logic       per_en,
    output logic       sec_tick
);
    busrate_div #(.SEL_W(2)) bus_div_i (
        .clk    (clk_core),
        .rst_n  (rst_core_n),
        .sel    (bus_sel),
        .gate   (gate_req),
        .strobe (bus_en)
    );

    perrate_div per_div_i (
        .clk    (clk_core),
        .rst_n  (rst_core_n),
        .sel    (per_sel),
        .adv    (bus_en),
        .strobe (per_en)
    );

    sec_prescaler #(.DIV(SLOW_DIV)) sec_div_i (
        .clk   (clk_slow),
        .rst_n (rst_slow_n),
        .tick  (sec_tick)
    );
endmodule

// File: rtl/sysclk_strobe_gen_chk.sv
module sysclk_strobe_gen_chk (
    input logic       clk_core,
    input logic       rst_core_n,
    input logic       clk_slow,
    input logic       rst_slow_n,
    input logic [1:0] bus_sel,
    input logic       gate_req,
    input logic       bus_en,
    input logic       per_en,
    input logic       sec_tick
);
    AST_PER_INSIDE_BUS: assert property (@(posedge clk_core) disable iff (!rst_core_n)
        per_en |-> bus_en); // R4
    AST_GATE_STALLS_PER: assert property (@(posedge clk_core) disable iff (!rst_core_n)
        gate_req |-> !per_en); // R6
    AST_PER_NO_REPEAT: assert property (@(posedge clk_core) disable iff (!rst_core_n)
        per_en |=> !per_en); // R4
    AST_DIV1_STAYS_HIGH: assert property (@(posedge clk_core) disable iff (!rst_core_n)
        ($past(bus_en) && !gate_req && bus_sel == 2'd0) |-> bus_en); // R2
    AST_NO_SHORT_PERIOD: assert property (@(posedge clk_core) disable iff (!rst_core_n)
        ($past(bus_en) && bus_en) |-> (bus_sel == 2'd0)); // R8
    AST_TICK_SINGLE: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        sec_tick |=> !sec_tick); // R10
endmodule

bind sysclk_strobe_gen sysclk_strobe_gen_chk chk_i (.*);

// File: tb/sysclk_strobe_gen_tb_top.sv
module sysclk_strobe_gen_tb_top;
    logic clk_core = 1'b0;
    logic clk_slow = 1'b0;
    bit   core_run = 1'b1;
    logic rst_core_n = 1'b0, rst_slow_n = 1'b0;
    logic [1:0] bus_sel = 2'd0, per_sel = 2'd0;
    logic gate_req = 1'b0;
    logic bus_en, per_en, sec_tick;

    int vectors = 0, miscompares = 0;
    int m_bus_left, m_per_left;

    always #10 if (core_run) clk_core = ~clk_core;
    always #3 clk_slow = ~clk_slow;

    sysclk_strobe_gen dut_i (.*);

    function automatic int bus_len(input logic [1:0] s);
        return int'(s) + 1;
    endfunction

    function automatic int per_len(input logic [1:0] s);
        case (s)
            2'd0: return 2;
            2'd1: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic core_reset();
        rst_core_n = 1'b0;
        bus_sel = 2'd0; per_sel = 2'd0; gate_req = 1'b0;
        @(posedge clk_core); #1;
        @(posedge clk_core); #9;
        check("R9", "bus_en in reset", int'(bus_en), 0);
        check("R9", "per_en in reset", int'(per_en), 0);
        @(posedge clk_core); #1;
        rst_core_n = 1'b1;
        m_bus_left = 0;
        m_per_left = 0;
    endtask

    // one core cycle: called at posedge+1, returns at next posedge+1
    task automatic step(input logic [1:0] bs, input logic [1:0] ps, input logic g,
                        input string req, output logic got_bus, output logic got_per);
        logic eb, ep;
        bus_sel = bs; per_sel = ps; gate_req = g;
        #8;
        if (m_bus_left == 0) m_bus_left = bus_len(bs);
        eb = (m_bus_left == 1) && !g;
        ep = 1'b0;
        if (eb) begin
            if (m_per_left == 0) m_per_left = per_len(ps);
            ep = (m_per_left == 1);
        end
        check(req, "bus_en", int'(bus_en), int'(eb));
        check(req, "per_en", int'(per_en), int'(ep));
        got_bus = bus_en;
        got_per = per_en;
        m_bus_left--;
        if (eb) m_per_left--;
        @(posedge clk_core); #1;
    endtask

    task automatic run(input int n, input logic [1:0] bs, input logic [1:0] ps,
                       input logic g, input string req, output int nb, output int np);
        logic b, p;
        nb = 0; np = 0;
        for (int i = 0; i < n; i++) begin
            step(bs, ps, g, req, b, p);
            nb += int'(b);
            np += int'(p);
        end
    endtask

    initial begin
        #5ms;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int nb, np;
        logic b, p;
        logic [1:0] rbs, rps;
        logic rg;
        void'($urandom(32'h5EC0_1D5E));

        // R2 and R9: divide-by-1 right after reset
        core_reset();
        run(16, 2'd0, 2'd0, 1'b0, "R2", nb, np);
        check("R2", "bus pulses in 16 cycles", nb, 16);
        check("R4", "per pulses div2 over 16 bus", np, 8);

        // R3: divide-by-3
        core_reset();
        run(12, 2'd2, 2'd1, 1'b0, "R3", nb, np);
        check("R3", "bus pulses in 12 cycles", nb, 4);
        check("R9", "first per pulse on 4th bus strobe", np, 1);

        // R1: divide-by-2 and divide-by-4
        core_reset();
        run(16, 2'd1, 2'd0, 1'b0, "R1", nb, np);
        check("R1", "div2 pulses in 16", nb, 8);
        core_reset();
        run(16, 2'd3, 2'd0, 1'b0, "R1", nb, np);
        check("R1", "div4 pulses in 16", nb, 4);

        // R5: spare peripheral code gives divide-by-8
        core_reset();
        run(24, 2'd0, 2'd3, 1'b0, "R5", nb, np);
        check("R5", "per pulses in 24 bus strobes", np, 3);

        // R6 and R7: gate in the middle of a peripheral period
        core_reset();
        run(3, 2'd0, 2'd2, 1'b0, "R7", nb, np);
        run(10, 2'd0, 2'd2, 1'b1, "R6", nb, np);
        check("R6", "bus pulses while gated", nb, 0);
        run(5, 2'd0, 2'd2, 1'b0, "R7", nb, np);
        check("R7", "per resumes after 8 total strobes", np, 1);

        // R8: select change mid-period waits for the wrap
        core_reset();
        step(2'd3, 2'd0, 1'b0, "R8", b, p);
        run(3, 2'd0, 2'd0, 1'b0, "R8", nb, np);
        check("R8", "div4 period completes despite change", nb, 1);

        // R8: random select changes and gating
        core_reset();
        rbs = 2'd1; rps = 2'd0; rg = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) rbs = 2'($urandom_range(3));
            if ($urandom_range(15) == 0) rps = 2'($urandom_range(3));
            if ($urandom_range(19) == 0) rg = ~rg;
            step(rbs, rps, rg, "R8", b, p);
        end

        // R10 and R11: slow section with the core stopped and in reset
        rst_core_n = 1'b0;
        core_run = 1'b0;
        @(posedge clk_slow); #1;
        rst_slow_n = 1'b1;
        for (int n = 0; n < 2 * 32768 + 4; n++) begin
            #1;
            check((n % 32768 == 32767) ? "R10" : "R11", "sec_tick",
                  int'(sec_tick), int'(n % 32768 == 32767));
            @(posedge clk_slow); #1;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule